// File: doc/BRIEF.md
# Serial Flash Burst Read Engine

This block is a register-mapped controller that reads a serial flash device in bursts of up to 64 bytes. Software loads a flash byte address, then writes a control word that carries a cycle type, a length-minus-one count and a start bit. The engine sends a plain read command (opcode 0x03 followed by a 24-bit address, most significant byte first) over a single-bit SPI link and captures the returned bytes into a bank of sixteen 32-bit data words. When the burst finishes, or when the request is refused, a flag in the status word tells software what happened. Software polls that word and clears the flags by writing back the value it read.

The serial clock runs at the system clock divided by `2*HALF_DIV`, in SPI mode 0. Chip select stays low from the command byte to the last data byte. Requests that would run past the configured flash size are refused rather than wrapped.

Top module: `sfr_burst_reader`

## Requirements
- R1: After reset the status, control and address words read 0, `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: A write to the address word (index 2) updates only bits 23:0. Bits 31:24 cannot be written and read 0.
- R3: A start request (write to the control word, index 1, with bit 0 set and type bits 2:1 equal to 0) produces one chip-select-low frame. The frame carries 0x03, then address bits 23:0 MSB first, then exactly count+1 data bytes, and ends with `spi_cs_n` returning high.
- R4: SPI mode 0 is used. `spi_sck` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sck` is low. `spi_miso` is sampled on the rising edge. Each SCK high phase lasts `HALF_DIV` clocks.
- R5: Burst byte i lands in data word i/4, at index 4+i/4, in bits 8*(i%4)+7 : 8*(i%4), so the first byte is least significant.
- R6: Status bit 2 (busy) is 1 while a burst runs. Status bit 0 (done) becomes 1 once the frame has closed.
- R7: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 there leaves it unchanged.
- R8: A start request made while busy is ignored. It sets status bit 1 (error), and the running burst completes with its original address and length.
- R9: A start request with a nonzero type sets the error flag and produces no chip-select activity.
- R10: A start request whose address + count + 1 exceeds `FLASH_BYTES` sets the error flag and produces no frame. A burst that ends exactly at `FLASH_BYTES` is accepted.
- R11: Writing 1 to status bit 15 sets a lock flag. The flag reads 1 from then on, whatever is written, until reset.
- R12: The count field is control bits 13:8. A value of 63 moves 64 bytes, and a value of 0 moves one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 5 | Word index of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that `spi_miso` is only meaningful inside a frame, and that the register bus writes at most one word per cycle. The bench's flash model drives MISO only on SCK falling edges while chip select is low, and each register access is a single-cycle strobe. The assertions also assume that the address word is not rewritten in the middle of a burst. The engine latches the address at start, and the stimulus changes the address only between bursts, including in the collision test, where only the control word is written a second time.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned REG_IDX_W  = 5;
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_CTRL   = 1;
  localparam int unsigned IDX_ADDR   = 2;
  localparam int unsigned IDX_DATA0  = 4;

  localparam int unsigned BURST_MAX  = 64;
  localparam int unsigned DATA_WORDS = BURST_MAX / 4;
  localparam int unsigned CNT_W      = $clog2(BURST_MAX);
  localparam int unsigned CNT_LSB    = 8;
  localparam int unsigned FADDR_W    = 24;
  localparam int unsigned HDR_BYTES  = 1 + FADDR_W / 8;

  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_BUSY = 2;
  localparam int unsigned ST_LOCK = 15;

  localparam logic [7:0] OP_READ = 8'h03;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_RUN, SEQ_FIN} seq_state_t;

  typedef struct packed {
    logic [FADDR_W-1:0] addr;
    logic [CNT_W-1:0]   cnt_m1;
  } burst_req_t;
endpackage

// File: rtl/sfr_spi_shift.sv
module sfr_spi_shift
  import sfr_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_go,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic             active_q, sck_q, mosi_q, done_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q, rx_q;

  // named phase events
  wire tick_ev = active_q && (div_q == DIV_W'(HALF_DIV - 1));
  wire rise_ev = tick_ev && !sck_q;
  wire fall_ev = tick_ev && sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0; sck_q <= 1'b0; mosi_q <= 1'b0; done_q <= 1'b0;
      div_q <= '0; bit_q <= '0; sh_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (byte_go && !active_q) begin
        active_q <= 1'b1;
        sh_q     <= tx_byte;
        mosi_q   <= tx_byte[7];
        bit_q    <= '0;
        div_q    <= '0;
        sck_q    <= 1'b0;
      end else if (active_q) begin
        if (tick_ev) div_q <= '0;
        else         div_q <= div_q + DIV_W'(1);
        if (rise_ev) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], spi_miso};
        end
        if (fall_ev) begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q  <= bit_q + 3'd1;
            sh_q   <= {sh_q[6:0], 1'b0};
            mosi_q <= sh_q[6];
          end
        end
      end
    end
  end

  assign spi_sck   = sck_q;
  assign spi_mosi  = mosi_q;
  assign rx_byte   = rx_q;
  assign byte_done = done_q;

  // R4: data line holds while the clock is high
  assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));
endmodule

// File: rtl/sfr_burst_seq.sv
module sfr_burst_seq
  import sfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  burst_req_t       req,
  output logic             busy,
  output logic             fin,
  output logic             cs_n,
  output logic             byte_go,
  output logic [7:0]       tx_byte,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_pos,
  output logic [7:0]       wr_byte
);
  localparam int unsigned STEP_W = CNT_W + 1;

  seq_state_t        st_q;
  burst_req_t        req_q;
  logic [STEP_W-1:0] step_q;
  logic              launch_q, cs_q;

  function automatic logic [7:0] hdr_byte(input logic [STEP_W-1:0] s,
                                          input logic [FADDR_W-1:0] a);
    case (s)
      STEP_W'(0): return OP_READ;
      STEP_W'(1): return a[23:16];
      STEP_W'(2): return a[15:8];
      STEP_W'(3): return a[7:0];
      default:    return 8'h00;
    endcase
  endfunction

  wire [STEP_W-1:0] last_step = STEP_W'(req_q.cnt_m1) + STEP_W'(HDR_BYTES);
  wire              in_data   = step_q >= STEP_W'(HDR_BYTES);
  wire              last_ev   = byte_done && (step_q == last_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE; req_q <= '0; step_q <= '0; launch_q <= 1'b0; cs_q <= 1'b1;
    end else begin
      launch_q <= 1'b0;
      case (st_q)
        SEQ_IDLE: if (start) begin
          req_q    <= req;
          step_q   <= '0;
          launch_q <= 1'b1;
          cs_q     <= 1'b0;
          st_q     <= SEQ_RUN;
        end
        SEQ_RUN: if (last_ev) begin
          cs_q <= 1'b1;
          st_q <= SEQ_FIN;
        end else if (byte_done) begin
          step_q   <= step_q + STEP_W'(1);
          launch_q <= 1'b1;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != SEQ_IDLE);
  assign fin     = (st_q == SEQ_FIN);
  assign cs_n    = cs_q;
  assign byte_go = launch_q;
  assign tx_byte = hdr_byte(step_q, req_q.addr);
  assign wr_en   = byte_done && in_data;
  assign wr_pos  = CNT_W'(step_q - STEP_W'(HDR_BYTES));
  assign wr_byte = rx_byte;

  // R8: a new burst is only accepted when idle
  assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R3: every byte completes inside the chip-select window
  assert_byte_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !cs_n);
endmodule

// File: rtl/sfr_regs.sv
module sfr_regs
  import sfr_pkg::*;
#(
  parameter int unsigned FLASH_BYTES = 1 << 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 seq_busy,
  input  logic                 seq_fin,
  input  logic                 wr_en,
  input  logic [CNT_W-1:0]     wr_pos,
  input  logic [7:0]           wr_byte,
  output logic                 start,
  output burst_req_t           req
);
  localparam int unsigned EXT_W = FADDR_W + 2;

  logic               done_q, err_q, lock_q;
  logic [1:0]         ctype_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FADDR_W-1:0] addr_q;
  logic [31:0]        data_q [DATA_WORDS];

  function automatic logic burst_fits(input logic [FADDR_W-1:0] a,
                                      input logic [CNT_W-1:0] c);
    logic [EXT_W-1:0] end_x;
    end_x = EXT_W'(a) + EXT_W'(c) + EXT_W'(1);
    return end_x <= EXT_W'(FLASH_BYTES);
  endfunction

  wire st_wr  = reg_wr && (reg_idx == REG_IDX_W'(IDX_STATUS));
  wire ctl_wr = reg_wr && (reg_idx == REG_IDX_W'(IDX_CTRL));
  wire adr_wr = reg_wr && (reg_idx == REG_IDX_W'(IDX_ADDR));

  wire [1:0]       w_type = reg_wdata[2:1];
  wire [CNT_W-1:0] w_cnt  = reg_wdata[CNT_LSB +: CNT_W];
  wire             go_req = ctl_wr && reg_wdata[0];

  // named request outcomes
  wire go_collide = go_req && seq_busy;
  wire go_badtype = go_req && !seq_busy && (w_type != 2'd0);
  wire go_range   = go_req && !seq_busy && (w_type == 2'd0) && !burst_fits(addr_q, w_cnt);
  wire err_ev     = go_collide || go_badtype || go_range;
  wire unused_hi  = ^reg_wdata[31:FADDR_W];

  assign start = go_req && !seq_busy && (w_type == 2'd0) && burst_fits(addr_q, w_cnt);
  assign req   = '{addr: addr_q, cnt_m1: w_cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; err_q <= 1'b0; lock_q <= 1'b0;
      ctype_q <= '0; cnt_q <= '0; addr_q <= '0;
      for (int k = 0; k < DATA_WORDS; k++) data_q[k] <= '0;
    end else begin
      if (seq_fin)                         done_q <= 1'b1;
      else if (st_wr && reg_wdata[ST_DONE]) done_q <= 1'b0;
      if (err_ev)                          err_q <= 1'b1;
      else if (st_wr && reg_wdata[ST_ERR])  err_q <= 1'b0;
      if (st_wr && reg_wdata[ST_LOCK])      lock_q <= 1'b1;
      if (ctl_wr && !seq_busy) begin
        ctype_q <= w_type;
        cnt_q   <= w_cnt;
      end
      if (adr_wr) addr_q <= reg_wdata[FADDR_W-1:0];
      if (wr_en) data_q[wr_pos[CNT_W-1:2]][{wr_pos[1:0], 3'b000} +: 8] <= wr_byte;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_idx == REG_IDX_W'(IDX_STATUS)) begin
      reg_rdata[ST_DONE] = done_q;
      reg_rdata[ST_ERR]  = err_q;
      reg_rdata[ST_BUSY] = seq_busy;
      reg_rdata[ST_LOCK] = lock_q;
    end else if (reg_idx == REG_IDX_W'(IDX_CTRL)) begin
      reg_rdata[2:1]                = ctype_q;
      reg_rdata[CNT_LSB +: CNT_W]   = cnt_q;
    end else if (reg_idx == REG_IDX_W'(IDX_ADDR)) begin
      reg_rdata[FADDR_W-1:0] = addr_q;
    end else begin
      for (int k = 0; k < DATA_WORDS; k++)
        if (reg_idx == REG_IDX_W'(IDX_DATA0 + k)) reg_rdata = data_q[k];
    end
  end

  // R6: done is raised once the sequencer closes the frame
  assert_done_after_fin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fin |=> done_q);
  // R8: a start request while busy flags an error
  assert_collide_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == REG_IDX_W'(IDX_CTRL) && reg_wdata[0] && seq_busy) |=> err_q);
  // R11: the lock flag never drops
  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

// File: rtl/sfr_burst_reader.sv
module sfr_burst_reader
  import sfr_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 2,
  parameter int unsigned FLASH_BYTES = 1 << 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic             start, seq_busy, seq_fin, byte_go, byte_done, wr_en;
  logic [7:0]       tx_byte, rx_byte, wr_byte;
  logic [CNT_W-1:0] wr_pos;
  burst_req_t       req;

  sfr_regs #(.FLASH_BYTES(FLASH_BYTES)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_busy(seq_busy),
    .seq_fin(seq_fin), .wr_en(wr_en), .wr_pos(wr_pos), .wr_byte(wr_byte),
    .start(start), .req(req));

  sfr_burst_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .busy(seq_busy),
    .fin(seq_fin), .cs_n(spi_cs_n), .byte_go(byte_go), .tx_byte(tx_byte),
    .byte_done(byte_done), .rx_byte(rx_byte), .wr_en(wr_en),
    .wr_pos(wr_pos), .wr_byte(wr_byte));

  sfr_spi_shift #(.HALF_DIV(HALF_DIV)) shift_i (
    .clk(clk), .rst_n(rst_n), .byte_go(byte_go), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .byte_done(byte_done), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // R4: clock rests low outside a frame
  assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
endmodule

// File: tb/sfr_burst_reader_tb_top.sv
module sfr_burst_reader_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned HALF       = 2;
  localparam int unsigned FLASH      = 1 << 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfr_burst_reader #(.HALF_DIV(HALF), .FLASH_BYTES(FLASH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    return a[7:0] ^ {a[10:8], a[15:11]} ^ a[19:12] ^ 8'hA5;
  endfunction

  // flash model
  int unsigned bitcnt = 0;
  int frames = 0;
  logic [31:0] hdr = '0;
  always @(negedge spi_cs_n) begin bitcnt = 0; hdr = '0; frames++; end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (bitcnt < 32) hdr = {hdr[30:0], spi_mosi};
    bitcnt++;
  end
  always @(negedge spi_sck) if (!spi_cs_n && bitcnt >= 32) begin
    int unsigned k;
    logic [7:0] b;
    k = bitcnt - 32;
    b = fbyte({8'h00, hdr[23:0]} + k / 8);
    spi_miso = b[7 - (k % 8)];
  end

  // SCK high-phase width monitor
  int hi_run = 0, hi_bad = 0, hi_seen = 0;
  always @(negedge clk) begin
    if (spi_sck) hi_run++;
    else if (hi_run != 0) begin
      hi_seen++;
      if (hi_run != HALF) hi_bad++;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] i, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] i, output logic [31:0] d);
    @(negedge clk); reg_idx = i; #1 d = reg_rdata;
  endtask

  task automatic poll(input logic [31:0] mask, output logic [31:0] s);
    s = '0;
    for (int t = 0; t < 20000; t++) begin
      rd(5'd0, s);
      if ((s & mask) != 0) break;
    end
  endtask

  task automatic check_data(input logic [23:0] a, input int cnt);
    for (int w = 0; w <= cnt / 4; w++) begin
      logic [31:0] act, exp, msk;
      exp = '0; msk = '0;
      for (int b = 0; b < 4; b++) begin
        if (4*w + b <= cnt) begin
          exp[8*b +: 8] = fbyte({8'h00, a} + 32'(4*w + b));
          msk[8*b +: 8] = 8'hFF;
        end
      end
      rd(5'(4 + w), act);
      chk((act & msk) == exp, "R5 data word", act & msk, exp);
    end
  endtask

  task automatic burst(input logic [23:0] a, input int cnt, input logic [1:0] ty, input bit ok);
    int f0;
    logic [31:0] s;
    f0 = frames;
    wr(5'd2, {8'h00, a});
    wr(5'd1, (32'(cnt) << 8) | (32'(ty) << 1) | 32'd1);
    poll(32'h3, s);
    repeat (4) @(negedge clk);
    rd(5'd0, s);
    if (ok) begin
      chk(s[2:0] == 3'b001, "R6 done flag", s, 32'h1);
      chk(frames == f0 + 1, "R3 one frame", frames, f0 + 1);
      chk(hdr == {8'h03, a}, "R3 header", hdr, {8'h03, a});
      chk(bitcnt == 32'(8 * (5 + cnt)), "R12 bit count", bitcnt, 8 * (5 + cnt));
      chk(spi_cs_n === 1'b1, "R3 cs released", spi_cs_n, 1);
      check_data(a, cnt);
    end else begin
      chk(s[1:0] == 2'b10, ty != 0 ? "R9 error flag" : "R10 error flag", s, 32'h2);
      chk(frames == f0, ty != 0 ? "R9 no frame" : "R10 no frame", frames, f0);
    end
    wr(5'd0, s);
    rd(5'd0, s);
    chk(s[1:0] == 2'b00, "R7 w1c clear", s, 0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'd0, v); chk(v == 0, "R1 status reset", v, 0);
    rd(5'd1, v); chk(v == 0, "R1 control reset", v, 0);
    rd(5'd2, v); chk(v == 0, "R1 address reset", v, 0);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 pins idle", {spi_cs_n, spi_sck}, 2'b10);
    // R2 address field only
    wr(5'd2, 32'hFFFF_FFFF); rd(5'd2, v);
    chk(v == 32'h00FF_FFFF, "R2 address field", v, 32'h00FF_FFFF);
    // directed bursts
    burst(24'h000000, 0, 2'd0, 1);                    // R12 single byte
    burst(24'h012345, 63, 2'd0, 1);                   // R12 full 64 bytes
    burst(24'(FLASH - 64), 63, 2'd0, 1);              // R10 ends exactly at size
    burst(24'(FLASH - 10), 15, 2'd0, 0);              // R10 crosses size
    burst(24'h000100, 3, 2'd2, 0);                    // R9 bad type
    // R7 writing zero leaves an error flag set
    wr(5'd2, 24'h000100); wr(5'd1, 32'h0000_0003);
    wr(5'd0, 32'h0); rd(5'd0, v);
    chk(v[1] == 1'b1, "R7 zero keeps flag", v, 32'h2);
    wr(5'd0, 32'h2);
    // R8 start request while busy
    begin
      int f0;
      f0 = frames;
      wr(5'd2, 24'h0A0B0C); wr(5'd1, 32'h0000_0701);
      repeat (20) @(negedge clk);
      rd(5'd0, v); chk(v[2] == 1'b1, "R6 busy", v, 32'h4);
      wr(5'd1, 32'h0000_0301);
      rd(5'd0, v); chk(v[1] == 1'b1, "R8 collide error", v, 32'h2);
      poll(32'h1, v);
      repeat (4) @(negedge clk);
      chk(frames == f0 + 1, "R8 single frame", frames, f0 + 1);
      chk(bitcnt == 32'(8 * 12), "R8 original length", bitcnt, 96);
      check_data(24'h0A0B0C, 7);
      rd(5'd0, v); wr(5'd0, v);
    end
    // random bursts
    for (int r = 0; r < 20; r++) begin
      logic [23:0] a;
      int c;
      a = 24'($urandom % (FLASH - 64));
      c = int'($urandom % 64);
      burst(a, c, 2'd0, 1);
    end
    // R4 timing
    chk(hi_bad == 0 && hi_seen > 0, "R4 high phase width", hi_bad, 0);
    // R11 lock
    wr(5'd0, 32'h0000_8000); rd(5'd0, v);
    chk(v[15] == 1'b1, "R11 lock set", v, 32'h8000);
    wr(5'd0, 32'h0); rd(5'd0, v);
    chk(v[15] == 1'b1, "R11 lock sticky", v, 32'h8000);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule